// File: doc/BRIEF.md
# SDRAM Column Command Sequencer

This block sits between a memory controller's request queue and the pins of an SDR SDRAM whose target row has already been activated. Each accepted request becomes one column command, read or write, on the active-low command strobes. It carries the bank select, the starting column and a per-request auto-precharge choice. When that choice is set the device closes the row after the burst; otherwise the row stays open for further column accesses. The block then runs the data phase of the burst.

The per-byte data mask has different timing in the two directions. On writes each mask byte goes out in the same cycle as the data beat it gates. On reads the device samples the mask two clocks before the beat it controls. The sequencer therefore schedules read masks ahead of the data, and a small capture pipeline delays the mask so that each returned byte is flagged valid or invalid. A masked byte is high-impedance at the device, so the data on it has no meaning.

CAS latency (2 or 3) and burst length (1, 2, 4 or 8) are fixed at elaboration. A request carries its whole burst of write data and byte enables. For a read, the byte enables choose the bytes to fetch.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the strobes show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). All mask lines are high, the output enable is low, `req_ready` is high, and `rd_valid` and `rd_byte_valid` are low. Reset in the middle of a burst cancels any read data still pending.
- R2: A read accepted on a clock edge drives cs_n=0, ras_n=1, cas_n=0, we_n=1 in the next cycle, with `sd_ba` equal to the request bank.
- R3: An accepted write drives cs_n=0, ras_n=1, cas_n=0, we_n=0 in the cycle after acceptance, with `sd_ba` equal to the request bank.
- R4: In the command cycle, `sd_addr` bits [COL_W-1:0] carry the request column, bit AP_BIT (10 by default) equals the auto-precharge flag, and every other address bit is 0.
- R5: For a write, counting the command cycle as cycle 0, cycle i (0 ≤ i < BURST_LEN) drives data beat i from `req_wdata[i*DATA_W +: DATA_W]`. In the same cycle `sd_dqm` equals the inverse of `req_be[i*BYTES +: BYTES]` and `sd_dq_oe` is high. In every other cycle `sd_dq_oe` is low.
- R6: For a read, `sd_dqm` in cycle CAS_LAT+i-2 equals the inverse of the byte enables of beat i. In every other cycle `sd_dqm` is all ones.
- R7: The word on `sd_dq_in` in cycle CAS_LAT+i is returned on `rd_data` with `rd_valid` high in cycle CAS_LAT+i+1. `rd_byte_valid[b]` equals the enable of byte b for beat i, and data bytes flagged invalid read as 0. When `rd_valid` is low, `rd_byte_valid` is 0.
- R8: `req_ready` goes low from the command cycle until the burst's data cycles are done. It is high again in cycle BURST_LEN after a write and in cycle CAS_LAT+BURST_LEN after a read. A request held valid while `req_ready` is low issues no command.
- R9: Whenever `req_ready` is high, the strobes show NOP and all mask lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_ap | input | 1 | Auto-precharge after the burst |
| req_wdata | input | BURST_LEN*DATA_W | Write data, beat 0 in the low bits |
| req_be | input | BURST_LEN*DATA_W/8 | Byte enables per beat, beat 0 in the low bits |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Column address and auto-precharge bit |
| sd_dqm | output | DATA_W/8 | Byte mask, high = masked |
| sd_dq_out | output | DATA_W | Write data to the pad |
| sd_dq_oe | output | 1 | Pad output enable |
| sd_dq_in | input | DATA_W | Data from the pad |
| rd_valid | output | 1 | Returned read beat present |
| rd_data | output | DATA_W | Returned read beat |
| rd_byte_valid | output | DATA_W/8 | Per-byte validity of the returned beat |

## Verification
A wrong burst counter shows up within one burst. It moves the cycle in which `req_ready` rises, or it leaves `sd_dq_oe` and the mask active for a missing or an extra beat. A mask scheduled one cycle off shows at once, because each read beat's mask must appear exactly two cycles before that beat's data. An error in the capture delay is seen when the first read beat returns: `rd_valid` arrives a cycle early or late, or its byte flags are paired with the wrong beat's enables. A faulty command register is seen in the command cycle itself, on the strobes or on address bit 10.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_READ  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
  localparam sd_cmd_t CMD_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

  // Read mask leads its data beat by this many clocks.
  localparam int MASK_LEAD = 2;

  function automatic int beat_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sdram_addr_fmt.sv
module sdram_addr_fmt #(
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    addr_o              = '0;
    addr_o[COL_W-1:0]   = col_i;
    addr_o[AP_BIT]      = ap_i;
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_col_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int DATA_W    = 16,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W-1:0]             req_bank,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [BURST_LEN*DATA_W-1:0]   req_wdata,
  input  logic [BURST_LEN*DATA_W/8-1:0] req_be,
  output sd_cmd_t                       cmd_o,
  output logic [BANK_W-1:0]             ba_o,
  output logic [ADDR_W-1:0]             addr_o,
  output logic [DATA_W/8-1:0]           dqm_o,
  output logic [DATA_W-1:0]             dq_o,
  output logic                          oe_o,
  output logic                          rd_slot_o
);

  localparam int BYTES    = DATA_W / 8;
  localparam int CYC_W    = $clog2(CAS_LAT + BURST_LEN + 1);
  localparam int BEAT_W   = beat_bits(BURST_LEN);
  localparam int MASK_OFS = CAS_LAT - MASK_LEAD;
  localparam logic [CYC_W-1:0] WR_LAST = CYC_W'(BURST_LEN - 1);
  localparam logic [CYC_W-1:0] RD_LAST = CYC_W'(CAS_LAT + BURST_LEN - 1);

  logic                                busy_q;
  logic                                wr_q;
  logic [CYC_W-1:0]                    cyc_q;
  logic [BURST_LEN-1:0][DATA_W-1:0]    wdata_q;
  logic [BURST_LEN-1:0][BYTES-1:0]     be_q;
  logic [BURST_LEN-1:0][DATA_W-1:0]    req_data_a;
  logic [BURST_LEN-1:0][BYTES-1:0]     req_be_a;

  logic [CYC_W-1:0]  nxt_cyc;
  logic              burst_end;
  logic              wr_beat;
  logic              rd_beat;
  logic [BEAT_W-1:0] wr_idx;
  logic [BEAT_W-1:0] rd_idx;

  assign req_data_a = req_wdata;
  assign req_be_a   = req_be;
  assign req_ready  = ~busy_q;

  always_comb begin
    nxt_cyc   = cyc_q + 1'b1;
    burst_end = wr_q ? (cyc_q == WR_LAST) : (cyc_q == RD_LAST);
    wr_beat   = int'(nxt_cyc) < BURST_LEN;
    rd_beat   = (int'(nxt_cyc) >= MASK_OFS) && (int'(nxt_cyc) < MASK_OFS + BURST_LEN);
    wr_idx    = BEAT_W'(nxt_cyc);
    rd_idx    = BEAT_W'(int'(nxt_cyc) - MASK_OFS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      wr_q      <= 1'b0;
      cyc_q     <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      cmd_o     <= CMD_NOP;
      ba_o      <= '0;
      addr_o    <= '0;
      dqm_o     <= '1;
      dq_o      <= '0;
      oe_o      <= 1'b0;
      rd_slot_o <= 1'b0;
    end else begin
      // defaults: idle pins
      cmd_o     <= CMD_NOP;
      ba_o      <= '0;
      addr_o    <= '0;
      dqm_o     <= '1;
      dq_o      <= '0;
      oe_o      <= 1'b0;
      rd_slot_o <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q  <= 1'b1;
          wr_q    <= req_write;
          cyc_q   <= '0;
          wdata_q <= req_data_a;
          be_q    <= req_be_a;
          ba_o    <= req_bank;
          addr_o  <= req_addr;
          if (req_write) begin
            cmd_o <= CMD_WRITE;
            dqm_o <= ~req_be_a[0];
            dq_o  <= req_data_a[0];
            oe_o  <= 1'b1;
          end else begin
            cmd_o <= CMD_READ;
            if (MASK_OFS == 0) begin
              dqm_o     <= ~req_be_a[0];
              rd_slot_o <= 1'b1;
            end
          end
        end
      end else begin
        cyc_q <= nxt_cyc;
        if (burst_end) begin
          busy_q <= 1'b0;
        end
        if (wr_q && wr_beat) begin
          dqm_o <= ~be_q[wr_idx];
          dq_o  <= wdata_q[wr_idx];
          oe_o  <= 1'b1;
        end else if (!wr_q && rd_beat) begin
          dqm_o     <= ~be_q[rd_idx];
          rd_slot_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LEAD   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  slot_i,
  input  logic [DATA_W/8-1:0]   mask_i,
  input  logic [DATA_W-1:0]     dq_i,
  output logic                  rd_valid_o,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic [DATA_W/8-1:0]   rd_byte_valid_o
);

  localparam int BYTES = DATA_W / 8;

  logic [LEAD-1:0]            slot_sr;
  logic [LEAD-1:0][BYTES-1:0] mask_sr;

  // Delay the mask by the read lead so it meets the beat it governs.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_sr <= '0;
      mask_sr <= '1;
    end else begin
      slot_sr[0] <= slot_i;
      mask_sr[0] <= mask_i;
      for (int s = 1; s < LEAD; s++) begin
        slot_sr[s] <= slot_sr[s-1];
        mask_sr[s] <= mask_sr[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid_o <= 1'b0;
    else     rd_valid_o <= slot_sr[LEAD-1];
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic keep;
    assign keep = slot_sr[LEAD-1] & ~mask_sr[LEAD-1][b];
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_byte_valid_o[b]     <= 1'b0;
        rd_data_o[b*8 +: 8]    <= '0;
      end else begin
        rd_byte_valid_o[b]     <= keep;
        rd_data_o[b*8 +: 8]    <= keep ? dq_i[b*8 +: 8] : 8'h00;
      end
    end
  end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int DATA_W    = 16,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [BANK_W-1:0]             req_bank,
  input  logic [COL_W-1:0]              req_col,
  input  logic                          req_ap,
  input  logic [BURST_LEN*DATA_W-1:0]   req_wdata,
  input  logic [BURST_LEN*DATA_W/8-1:0] req_be,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ADDR_W-1:0]             sd_addr,
  output logic [DATA_W/8-1:0]           sd_dqm,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic [DATA_W/8-1:0]           rd_byte_valid
);

  sd_cmd_t           cmd;
  logic [ADDR_W-1:0] req_addr;
  logic              rd_slot;

  sdram_addr_fmt #(
    .COL_W (COL_W),
    .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT)
  ) u_addr (
    .col_i (req_col),
    .ap_i  (req_ap),
    .addr_o(req_addr)
  );

  sdram_cmd_seq #(
    .BANK_W   (BANK_W),
    .COL_W    (COL_W),
    .ADDR_W   (ADDR_W),
    .AP_BIT   (AP_BIT),
    .DATA_W   (DATA_W),
    .CAS_LAT  (CAS_LAT),
    .BURST_LEN(BURST_LEN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_bank (req_bank),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .cmd_o    (cmd),
    .ba_o     (sd_ba),
    .addr_o   (sd_addr),
    .dqm_o    (sd_dqm),
    .dq_o     (sd_dq_out),
    .oe_o     (sd_dq_oe),
    .rd_slot_o(rd_slot)
  );

  sdram_rd_capture #(
    .DATA_W(DATA_W),
    .LEAD  (MASK_LEAD)
  ) u_cap (
    .clk            (clk),
    .rst            (rst),
    .slot_i         (rd_slot),
    .mask_i         (sd_dqm),
    .dq_i           (sd_dq_in),
    .rd_valid_o     (rd_valid),
    .rd_data_o      (rd_data),
    .rd_byte_valid_o(rd_byte_valid)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          req_write,
  input logic [BANK_W-1:0]             req_bank,
  input logic [COL_W-1:0]              req_col,
  input logic                          req_ap,
  input logic                          sd_cs_n,
  input logic                          sd_ras_n,
  input logic                          sd_cas_n,
  input logic                          sd_we_n,
  input logic [BANK_W-1:0]             sd_ba,
  input logic [ADDR_W-1:0]             sd_addr,
  input logic [DATA_W/8-1:0]           sd_dqm,
  input logic                          sd_dq_oe,
  input logic                          rd_valid,
  input logic [DATA_W/8-1:0]           rd_byte_valid
);

  logic accept;
  assign accept = req_valid && req_ready;

  p_read_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_write) |=> (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n
                                && sd_ba == $past(req_bank)));

  p_write_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write) |=> (!sd_cs_n && sd_ras_n && !sd_cas_n && !sd_we_n
                               && sd_ba == $past(req_bank)));

  p_ap_col_r4: assert property (@(posedge clk) disable iff (rst)
    accept |=> (sd_addr[AP_BIT] == $past(req_ap)
                && sd_addr[COL_W-1:0] == $past(req_col)));

  p_oe_off_idle_r5: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !sd_dq_oe);

  p_byte_flags_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_byte_valid == '0));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  p_idle_nop_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && (&sd_dqm)));

endmodule

bind sdram_col_seq sdram_col_seq_chk #(
  .BANK_W   (BANK_W),
  .COL_W    (COL_W),
  .ADDR_W   (ADDR_W),
  .AP_BIT   (AP_BIT),
  .DATA_W   (DATA_W),
  .BURST_LEN(BURST_LEN)
) u_chk (.*);

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 2;
  localparam int COL_W  = 9;
  localparam int ADDR_W = 13;
  localparam int AP_BIT = 10;
  localparam int DATA_W = 16;
  localparam int CL     = 2;
  localparam int BL     = 4;
  localparam int BYTES  = DATA_W / 8;

  typedef struct packed {
    logic        wr;
    logic [1:0]  bank;
    logic [8:0]  col;
    logic        ap;
    logic [63:0] data;
    logic [7:0]  be;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b1, 2'd1, 9'h004, 1'b0, 64'h4444_3333_2222_1111, 8'hFF},
    '{1'b0, 2'd2, 9'h1F8, 1'b1, 64'h0,                   8'hFF},
    '{1'b1, 2'd3, 9'h0A0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 8'b10_01_11_00},
    '{1'b0, 2'd0, 9'h155, 1'b0, 64'h0,                   8'b01_10_00_11},
    '{1'b1, 2'd2, 9'h0FF, 1'b0, 64'h1234_5678_9ABC_DEF0, 8'h00},
    '{1'b0, 2'd3, 9'h000, 1'b1, 64'h0,                   8'b00_11_10_01}
  };

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, req_write, req_ap;
  logic [BANK_W-1:0] req_bank;
  logic [COL_W-1:0] req_col;
  logic [BL*DATA_W-1:0] req_wdata;
  logic [BL*BYTES-1:0] req_be;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [BANK_W-1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;
  logic [BYTES-1:0] sd_dqm, rd_byte_valid;
  logic [DATA_W-1:0] sd_dq_out, sd_dq_in, rd_data;
  logic rd_valid;
  logic [15:0] tcnt = 16'd0;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 16'd1;

  function automatic logic [15:0] dev_word(input logic [15:0] t);
    return t * 16'd257 + 16'h1234;
  endfunction

  assign sd_dq_in = dev_word(tcnt);

  sdram_col_seq #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
    .DATA_W(DATA_W), .CAS_LAT(CL), .BURST_LEN(BL)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
    .req_wdata(req_wdata), .req_be(req_be), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_byte_valid(rd_byte_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, req,
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(sd_dqm == '1, req, sd_dqm, '1);
    chk(sd_dq_oe == 1'b0, req, sd_dq_oe, 0);
    chk(req_ready == 1'b1, req, req_ready, 1);
    chk(rd_valid == 1'b0 && rd_byte_valid == '0, req, {rd_valid, rd_byte_valid}, 0);
  endtask

  // Called at a falling edge inside a ready cycle; returns at the falling
  // edge of the next ready cycle.
  task automatic run_req(input vec_t v, input bit hold);
    logic [15:0] c0, dev;
    logic [3:0] exp_cmd;
    logic [ADDR_W-1:0] exp_addr;
    logic [BYTES-1:0] exp_dqm, exp_bv;
    logic [DATA_W-1:0] exp_rd;
    int last, j, i;
    string tg;
    req_valid = 1'b1; req_write = v.wr; req_bank = v.bank; req_col = v.col;
    req_ap = v.ap; req_wdata = v.data; req_be = v.be;
    last = v.wr ? BL : CL + BL;
    @(negedge clk);
    c0 = tcnt;
    if (!hold) req_valid = 1'b0;
    for (int k = 0; k <= last; k++) begin
      if (k > 0) @(negedge clk);
      if (hold && k == last) req_valid = 1'b0;
      exp_cmd = (k == 0) ? (v.wr ? 4'b0100 : 4'b0101) : 4'b0111;
      tg = (k == 0) ? (v.wr ? "R3 write cmd" : "R2 read cmd") : "R8 no cmd while busy";
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == exp_cmd, tg,
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, exp_cmd);
      if (k == 0) begin
        exp_addr = '0;
        exp_addr[COL_W-1:0] = v.col;
        exp_addr[AP_BIT] = v.ap;
        chk(sd_ba == v.bank, "R2 R3 bank", sd_ba, v.bank);
        chk(sd_addr == exp_addr, "R4 column and A10", sd_addr, exp_addr);
      end
      if (v.wr) begin
        exp_dqm = (k < BL) ? ~v.be[k*BYTES +: BYTES] : '1;
        chk(sd_dq_oe == (k < BL), "R5 write oe", sd_dq_oe, (k < BL));
        chk(sd_dqm == exp_dqm, "R5 write mask", sd_dqm, exp_dqm);
        if (k < BL)
          chk(sd_dq_out == v.data[k*DATA_W +: DATA_W], "R5 write data", sd_dq_out,
              v.data[k*DATA_W +: DATA_W]);
      end else begin
        j = k - (CL - 2);
        exp_dqm = (j >= 0 && j < BL) ? ~v.be[j*BYTES +: BYTES] : '1;
        chk(sd_dqm == exp_dqm, "R6 read mask lead", sd_dqm, exp_dqm);
        chk(sd_dq_oe == 1'b0, "R5 oe low on read", sd_dq_oe, 0);
      end
      chk(req_ready == (k == last), "R8 ready", req_ready, (k == last));
      if (!v.wr && k >= CL + 1 && k <= CL + BL) begin
        i = k - CL - 1;
        exp_bv = v.be[i*BYTES +: BYTES];
        dev = dev_word(c0 + 16'(CL + i));
        for (int b = 0; b < BYTES; b++)
          exp_rd[b*8 +: 8] = exp_bv[b] ? dev[b*8 +: 8] : 8'h00;
        chk(rd_valid == 1'b1, "R7 rd_valid", rd_valid, 1);
        chk(rd_byte_valid == exp_bv, "R7 byte valid", rd_byte_valid, exp_bv);
        chk(rd_data == exp_rd, "R7 read data", rd_data, exp_rd);
      end else begin
        chk(rd_valid == 1'b0 && rd_byte_valid == '0, "R7 no read beat",
            {rd_valid, rd_byte_valid}, 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_bank = '0; req_col = '0;
    req_ap = 1'b0; req_wdata = '0; req_be = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");

    // R2..R9: table walk
    for (int n = 0; n < 6; n++) run_req(VECS[n], 1'b0);

    // R8: request held valid through a busy write burst
    run_req(VECS[2], 1'b1);
    @(negedge clk);
    chk_idle("R9 idle after held request");
    // R8: back-to-back read, held valid
    run_req(VECS[3], 1'b1);

    // R1: reset in the middle of a read burst cancels pending data
    req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd1; req_col = 9'h010;
    req_ap = 1'b0; req_be = '1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R1 reset mid burst");
    for (int k = 0; k < CL + BL + 1; k++) begin
      @(negedge clk);
      chk(rd_valid == 1'b0, "R1 pending read cancelled", rd_valid, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule